// File: doc/BRIEF.md
# Strided Vector Load Unit

This block turns one vector memory operation into a stream of single-word bank accesses. A start pulse hands it a base word address, a stride and an element count. It walks the addresses base, base+stride, base+2·stride and so on, and sends each one to the memory bank named by the low address bits. Memory is word-interleaved across `NBANK` banks. Each bank has one port and a fixed access time of `BANK_LAT` cycles.

The unit keeps a countdown timer for every bank. When the next element maps to a bank that is still working, issue holds on that element, so later elements never overtake earlier ones. The stride therefore sets throughput. A stride with no common factor with the bank count streams one element per cycle. A stride that keeps hitting the same few banks is paced by the bank latency.

When a bank's time runs out, its word goes out on the vector-register write port at the element's index. A done pulse follows the final write.

Top module: `stride_vload`

## Requirements
- R1: Element i is requested at word address base + i·stride, wrapping modulo 2^ADDR_W, and that address is driven on `req_addr` in the same cycle as the request.
- R2: Each request raises only the `req_valid` bit whose number equals the low log2(NBANK) bits of the requested word address (bits [3:0] with 16 banks).
- R3: At most one request is made per cycle, and elements are requested and written back in strictly increasing index order starting at 0.
- R4: A bank that received a request in cycle t takes no other request before cycle t+BANK_LAT. Meanwhile issue stalls on the waiting element, so a stride that maps every element to one bank spaces requests exactly BANK_LAT cycles apart.
- R5: An element requested in cycle t is written in cycle t+BANK_LAT. In that cycle `wr_en` is 1, `wr_idx` is the element index and `wr_data` is the value its bank presents in that cycle.
- R6: The first request comes in the cycle right after the clock edge that takes `start`. With a stride that is odd for 16 banks, element i is requested i cycles after that, so VLEN elements finish writing BANK_LAT+VLEN−1 cycles after the first request.
- R7: `done` is a single-cycle pulse in the cycle after the last write. With a length of 0, no request is made and `done` pulses in the cycle right after the edge that takes `start`.
- R8: After reset and between operations, `busy`, `req_valid`, `wr_en` and `done` are 0. A `start` while `busy` is 1 is ignored, and so are the base, stride and length values presented with it.
- R9: A length above MAXVL is treated as MAXVL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| base | input | ADDR_W | First element word address |
| stride | input | ADDR_W | Word distance between consecutive elements (two's complement wrap) |
| vlen | input | VL_W = clog2(MAXVL+1) | Element count |
| req_valid | output | NBANK | One-hot bank access start |
| req_addr | output | ADDR_W | Word address of the access being started |
| bank_rdata | input | NBANK·DATA_W | Read data of every bank, bank b at bits [b·DATA_W +: DATA_W] |
| wr_en | output | 1 | Vector register write strobe |
| wr_idx | output | IDX_W = clog2(MAXVL) | Element index written |
| wr_data | output | DATA_W | Element value written |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The main function is driven with several stride types. Unit stride and other odd strides, including a wrapping base and a stride of −1, must stream without a single stall. Stride 2 fills half the banks and then stalls on the ninth element. Stride 8 alternates between two banks, and stride 16 stays on one bank, which exposes the exact reissue spacing. For each run the bench predicts the request cycle, address and bank of every element, plus the write cycle, index and data, and compares the whole stream. Directed runs cover a zero length, an over-long length that must be clamped, and a second start fired in mid-run that must change nothing.

// File: rtl/stride_vload_pkg.sv
package stride_vload_pkg;

   typedef enum logic {
      RUN_IDLE   = 1'b0,
      RUN_ACTIVE = 1'b1
   } run_state_t;

   function automatic int unsigned idx_bits(input int unsigned depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction

endpackage

// File: rtl/stride_vload_agen.sv
module stride_vload_agen
   import stride_vload_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int MAXVL  = 32,
   parameter int VL_W   = 6,
   parameter int IDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] stride,
   input  logic [VL_W-1:0]   vlen,
   input  logic              stall,
   input  logic              finish,
   output logic              running,
   output logic              fire,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [IDX_W-1:0]  cur_idx,
   output logic [VL_W-1:0]   vlen_q,
   output logic              zero_take
);

   localparam logic [VL_W-1:0] MAXVL_V = VL_W'(MAXVL);

   run_state_t        st_q;
   logic [VL_W-1:0]   cnt_q;
   logic [ADDR_W-1:0] stride_q;
   logic [VL_W-1:0]   vlen_eff;
   logic              pending;

   assign vlen_eff  = (vlen > MAXVL_V) ? MAXVL_V : vlen;
   assign running   = (st_q == RUN_ACTIVE);
   assign zero_take = (st_q == RUN_IDLE) && start && (vlen_eff == '0);
   assign pending   = running && (cnt_q < vlen_q);
   assign fire      = pending && !stall;
   assign cur_idx   = cnt_q[IDX_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= RUN_IDLE;
         cnt_q    <= '0;
         cur_addr <= '0;
         stride_q <= '0;
         vlen_q   <= '0;
      end else if (st_q == RUN_IDLE) begin
         if (start && (vlen_eff != '0)) begin
            st_q     <= RUN_ACTIVE;
            cur_addr <= base;
            stride_q <= stride;
            vlen_q   <= vlen_eff;
            cnt_q    <= '0;
         end
      end else begin
         if (fire) begin
            cur_addr <= cur_addr + stride_q;
            cnt_q    <= cnt_q + VL_W'(1);
         end
         if (finish) begin
            st_q <= RUN_IDLE;
         end
      end
   end

   AST_ISSUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (cnt_q <= vlen_q)) else $error("issue count past length"); // R3
   AST_LEN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (vlen_q <= MAXVL_V && vlen_q != '0)) else $error("length not clamped"); // R9

endmodule

// File: rtl/stride_vload_banks.sv
module stride_vload_banks #(
   parameter int NBANK = 16,
   parameter int LAT   = 11,
   parameter int IDX_W = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NBANK-1:0]       issue_vec,
   input  logic [IDX_W-1:0]       issue_idx,
   output logic [NBANK-1:0]       bank_busy,
   output logic [NBANK-1:0]       bank_done,
   output logic [NBANK*IDX_W-1:0] done_idx
);

   localparam int               CNT_W = $clog2(LAT + 1);
   localparam logic [CNT_W-1:0] LAT_V = CNT_W'(LAT);
   localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic [CNT_W-1:0] left_q;
      logic [IDX_W-1:0] elem_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            left_q <= '0;
            elem_q <= '0;
         end else if (issue_vec[b]) begin
            left_q <= LAT_V;
            elem_q <= issue_idx;
         end else if (left_q != '0) begin
            left_q <= left_q - ONE_V;
         end
      end

      assign bank_busy[b] = (left_q > ONE_V);
      assign bank_done[b] = (left_q == ONE_V);
      assign done_idx[b*IDX_W +: IDX_W] = elem_q;

      AST_BANK_SINGLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
         issue_vec[b] |-> (left_q <= ONE_V)) else $error("request to a busy bank"); // R4
   end

endmodule

// File: rtl/stride_vload_wb.sv
module stride_vload_wb #(
   parameter int NBANK  = 16,
   parameter int DATA_W = 16,
   parameter int IDX_W  = 5,
   parameter int VL_W   = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NBANK-1:0]        bank_done,
   input  logic [NBANK*IDX_W-1:0]  done_idx,
   input  logic [NBANK*DATA_W-1:0] bank_rdata,
   input  logic [VL_W-1:0]         vlen_q,
   input  logic                    active,
   input  logic                    zero_take,
   output logic                    wr_en,
   output logic [IDX_W-1:0]        wr_idx,
   output logic [DATA_W-1:0]       wr_data,
   output logic                    last_wr,
   output logic                    done
);

   always_comb begin
      wr_idx  = '0;
      wr_data = '0;
      for (int b = 0; b < NBANK; b++) begin
         if (bank_done[b]) begin
            wr_idx  = wr_idx  | done_idx[b*IDX_W +: IDX_W];
            wr_data = wr_data | bank_rdata[b*DATA_W +: DATA_W];
         end
      end
   end

   assign wr_en   = |bank_done;
   assign last_wr = wr_en && active && (VL_W'(wr_idx) == (vlen_q - VL_W'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done <= 1'b0;
      end else begin
         done <= last_wr || zero_take;
      end
   end

   logic [VL_W-1:0] next_exp_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         next_exp_q <= '0;
      end else if (last_wr) begin
         next_exp_q <= '0;
      end else if (wr_en) begin
         next_exp_q <= VL_W'(wr_idx) + VL_W'(1);
      end
   end

   AST_ONE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_done)) else $error("two banks retire together"); // R5
   AST_RETIRE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (VL_W'(wr_idx) == next_exp_q)) else $error("write out of order"); // R3

endmodule

// File: rtl/stride_vload.sv
module stride_vload
   import stride_vload_pkg::*;
#(
   parameter  int NBANK    = 16,
   parameter  int BANK_LAT = 11,
   parameter  int ADDR_W   = 16,
   parameter  int DATA_W   = 16,
   parameter  int MAXVL    = 32,
   localparam int VL_W     = $clog2(MAXVL + 1),
   localparam int IDX_W    = idx_bits(MAXVL)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [ADDR_W-1:0]       base,
   input  logic [ADDR_W-1:0]       stride,
   input  logic [VL_W-1:0]         vlen,
   output logic [NBANK-1:0]        req_valid,
   output logic [ADDR_W-1:0]       req_addr,
   input  logic [NBANK*DATA_W-1:0] bank_rdata,
   output logic                    wr_en,
   output logic [IDX_W-1:0]        wr_idx,
   output logic [DATA_W-1:0]       wr_data,
   output logic                    busy,
   output logic                    done
);

   localparam int BANK_W = idx_bits(NBANK);

   if (NBANK < 2 || (NBANK & (NBANK - 1)) != 0) begin : g_bad_nbank
      $error("NBANK must be a power of two of at least 2");
   end
   if (BANK_LAT < 1) begin : g_bad_lat
      $error("BANK_LAT must be at least 1");
   end
   if (MAXVL < 1) begin : g_bad_maxvl
      $error("MAXVL must be at least 1");
   end
   if (ADDR_W <= BANK_W || DATA_W < 1) begin : g_bad_width
      $error("ADDR_W must exceed the bank select width");
   end

   logic                    running;
   logic                    fire;
   logic                    stall;
   logic                    zero_take;
   logic                    last_wr;
   logic [ADDR_W-1:0]       cur_addr;
   logic [IDX_W-1:0]        cur_idx;
   logic [VL_W-1:0]         vlen_q;
   logic [BANK_W-1:0]       bank_sel;
   logic [NBANK-1:0]        issue_vec;
   logic [NBANK-1:0]        bank_busy;
   logic [NBANK-1:0]        bank_done;
   logic [NBANK*IDX_W-1:0]  done_idx;

   assign bank_sel  = cur_addr[BANK_W-1:0];
   assign stall     = bank_busy[bank_sel];
   assign issue_vec = fire ? (NBANK'(1) << bank_sel) : '0;
   assign req_valid = issue_vec;
   assign req_addr  = fire ? cur_addr : '0;
   assign busy      = running;

   stride_vload_agen #(
      .ADDR_W (ADDR_W),
      .MAXVL  (MAXVL),
      .VL_W   (VL_W),
      .IDX_W  (IDX_W)
   ) u_agen (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .base      (base),
      .stride    (stride),
      .vlen      (vlen),
      .stall     (stall),
      .finish    (last_wr),
      .running   (running),
      .fire      (fire),
      .cur_addr  (cur_addr),
      .cur_idx   (cur_idx),
      .vlen_q    (vlen_q),
      .zero_take (zero_take)
   );

   stride_vload_banks #(
      .NBANK (NBANK),
      .LAT   (BANK_LAT),
      .IDX_W (IDX_W)
   ) u_banks (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue_vec (issue_vec),
      .issue_idx (cur_idx),
      .bank_busy (bank_busy),
      .bank_done (bank_done),
      .done_idx  (done_idx)
   );

   stride_vload_wb #(
      .NBANK  (NBANK),
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W),
      .VL_W   (VL_W)
   ) u_wb (
      .clk        (clk),
      .rst_n      (rst_n),
      .bank_done  (bank_done),
      .done_idx   (done_idx),
      .bank_rdata (bank_rdata),
      .vlen_q     (vlen_q),
      .active     (running),
      .zero_take  (zero_take),
      .wr_en      (wr_en),
      .wr_idx     (wr_idx),
      .wr_data    (wr_data),
      .last_wr    (last_wr),
      .done       (done)
   );

   AST_BUSY_HOLDS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last_wr) |=> (vlen_q == $past(vlen_q))) else $error("start taken while busy"); // R8
   AST_DONE_FOLLOWS_WB: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(wr_en) || $past(zero_take))) else $error("done without final write"); // R7

endmodule

// File: tb/stride_vload_tb.sv
`timescale 1ns/1ps
module stride_vload_tb;

   localparam int NB  = 16;
   localparam int LAT = 11;
   localparam int AW  = 16;
   localparam int DW  = 16;
   localparam int MV  = 32;
   localparam int VW  = 6;
   localparam int IW  = 5;

   typedef struct packed {
      logic [15:0] b;
      logic [15:0] s;
      logic [5:0]  l;
      logic [7:0]  d;
   } vec_t;

   // base, stride, length, expected done cycle (relative to first request cycle)
   localparam int NVEC = 7;
   localparam vec_t VEC [NVEC] = '{
      '{16'h0000, 16'h0001, 6'd16, 8'd27},
      '{16'h0123, 16'h0003, 6'd20, 8'd31},
      '{16'h0040, 16'h0002, 6'd12, 8'd26},
      '{16'h0005, 16'h0010, 6'd4,  8'd45},
      '{16'hFFF0, 16'h0005, 6'd8,  8'd19},
      '{16'h0010, 16'hFFFF, 6'd10, 8'd21},
      '{16'h0100, 16'h0008, 6'd6,  8'd35}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [AW-1:0]     base = '0;
   logic [AW-1:0]     stride = '0;
   logic [VW-1:0]     vlen = '0;
   logic [NB-1:0]     req_valid;
   logic [AW-1:0]     req_addr;
   logic [NB*DW-1:0]  bank_rdata;
   logic              wr_en;
   logic [IW-1:0]     wr_idx;
   logic [DW-1:0]     wr_data;
   logic              busy;
   logic              done;

   always #10 clk = ~clk;

   stride_vload #(
      .NBANK(NB), .BANK_LAT(LAT), .ADDR_W(AW), .DATA_W(DW), .MAXVL(MV)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .base(base), .stride(stride),
      .vlen(vlen), .req_valid(req_valid), .req_addr(req_addr),
      .bank_rdata(bank_rdata), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .busy(busy), .done(done)
   );

   function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
      return a * 16'd3 + 16'h1111;
   endfunction

   // bank model: latch address on request, present its contents until the next one
   logic [AW-1:0] lat_addr [NB];
   initial for (int b = 0; b < NB; b++) lat_addr[b] = '0;
   always @(posedge clk) begin
      for (int b = 0; b < NB; b++) if (req_valid[b]) lat_addr[b] <= req_addr;
   end
   always_comb begin
      for (int b = 0; b < NB; b++) bank_rdata[b*DW +: DW] = memf(lat_addr[b]);
   end

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int nchk = 0;
   int nbad = 0;
   int s_cyc = 0;
   bit mon_on = 1'b0;
   int nreq, nwr, ndone, multi_req;
   int req_r [64]; int req_b [64]; logic [AW-1:0] req_a [64];
   int wr_r [64];  int wr_i [64];  logic [DW-1:0] wr_d [64];
   int done_r;
   int exp_r [64]; logic [AW-1:0] exp_a [64];

   always @(negedge clk) begin
      if (mon_on) begin
         int hits;
         hits = 0;
         if (|req_valid && nreq < 64) begin
            for (int b = 0; b < NB; b++) if (req_valid[b]) begin req_b[nreq] = b; hits++; end
            req_a[nreq] = req_addr;
            req_r[nreq] = cyc - s_cyc;
            nreq++;
         end
         if (hits > 1) multi_req++;
         if (wr_en && nwr < 64) begin
            wr_r[nwr] = cyc - s_cyc;
            wr_i[nwr] = int'(wr_idx);
            wr_d[nwr] = wr_data;
            nwr++;
         end
         if (done) begin
            if (ndone == 0) done_r = cyc - s_cyc;
            ndone++;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic run_vec(input logic [15:0] b, input logic [15:0] st, input logic [5:0] vl,
                          input int exp_done, input bit poke);
      int n;
      int t;
      int last_iss [NB];
      bit ok;
      int bad_at;
      n = (vl > 6'(MV)) ? MV : int'(vl);
      for (int k = 0; k < NB; k++) last_iss[k] = -1000;
      t = -1;
      for (int i = 0; i < n; i++) begin
         logic [AW-1:0] a;
         a = b + AW'(i) * st;
         t = (t + 1 > last_iss[a[3:0]] + LAT) ? t + 1 : last_iss[a[3:0]] + LAT;
         last_iss[a[3:0]] = t;
         exp_r[i] = t;
         exp_a[i] = a;
      end
      nreq = 0; nwr = 0; ndone = 0; multi_req = 0; done_r = -1;
      @(negedge clk);
      base = b; stride = st; vlen = vl; start = 1'b1;
      @(posedge clk);
      #1;
      s_cyc = cyc;
      mon_on = 1'b1;
      start = 1'b0;
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         #1;
         if (ndone > 0) break;
         if (poke && (cyc - s_cyc) == 3) begin
            start = 1'b1; base = 16'h7777; stride = 16'h0002; vlen = 6'd5;
         end else begin
            start = 1'b0;
         end
      end
      start = 1'b0;
      repeat (16) @(negedge clk);
      #1;
      mon_on = 1'b0;

      chk(ndone == 1, "R7", "done pulse count", ndone, 1);
      chk(done_r == exp_done, "R6 R7", "done cycle", done_r, exp_done);
      chk(nreq == n, "R1 R3", "request count", nreq, n);
      ok = 1'b1; bad_at = 0;
      for (int i = 0; i < n && i < nreq; i++) begin
         if (ok && (req_a[i] != exp_a[i] || req_b[i] != int'(exp_a[i][3:0]) || req_r[i] != exp_r[i])) begin
            ok = 1'b0; bad_at = i;
         end
      end
      chk(ok, "R1 R2 R4", "request addr/bank/cycle", ok ? 0 : req_r[bad_at], ok ? 0 : exp_r[bad_at]);
      if (!ok) $display("  element %0d addr %h bank %0d (want addr %h bank %0d)",
                        bad_at, req_a[bad_at], req_b[bad_at], exp_a[bad_at], exp_a[bad_at][3:0]);
      chk(nwr == n, "R5", "write count", nwr, n);
      ok = 1'b1; bad_at = 0;
      for (int i = 0; i < n && i < nwr; i++) begin
         if (ok && (wr_i[i] != i || wr_r[i] != exp_r[i] + LAT || wr_d[i] != memf(exp_a[i]))) begin
            ok = 1'b0; bad_at = i;
         end
      end
      chk(ok, "R5", "write idx/cycle/data", ok ? 0 : wr_d[bad_at], ok ? 0 : memf(exp_a[bad_at]));
      chk(multi_req == 0, "R3", "cycles with several requests", multi_req, 0);
      chk(busy == 1'b0, "R8", "busy after done", busy, 0);
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", nchk, nbad);
   endtask

   initial begin
      #(20 * 150000);
      nchk++; nbad++;
      $display("FAIL R7 watchdog: actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(req_valid == '0 && wr_en == 1'b0 && done == 1'b0 && busy == 1'b0,
          "R8", "outputs in reset", {req_valid, wr_en, done, busy}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(req_valid == '0 && wr_en == 1'b0 && done == 1'b0 && busy == 1'b0,
          "R8", "outputs idle after reset", {req_valid, wr_en, done, busy}, 0);

      for (int v = 0; v < NVEC; v++) begin
         run_vec(VEC[v].b, VEC[v].s, VEC[v].l, int'(VEC[v].d), 1'b0);
      end

      // R7: zero length gives done in the first cycle, no requests
      run_vec(16'h0042, 16'h0001, 6'd0, 0, 1'b0);
      // R9: length 40 clamps to 32
      run_vec(16'h0200, 16'h0001, 6'd40, 43, 1'b0);
      // R8: second start mid-run is ignored
      run_vec(16'h0300, 16'h0007, 6'd9, 20, 1'b1);

      summary();
      $finish;
   end

endmodule